// File: doc/BRIEF.md
# Circular Sample Window Store

This block keeps the latest DEPTH samples of a data stream so that a correlator can step through them. The samples sit in a plain memory array. A write pointer moves around the array, so a new sample lands in one slot and no other entry moves. Each accepted write puts one new sample into the slot that holds the oldest one, and that slot then holds the newest sample.

A consumer reads the window one entry per read enable. The read address is the write pointer plus a read position, taken modulo DEPTH. Position 0 is therefore the oldest sample and position DEPTH-1 the newest. The read position counts up by one on each read and wraps back to zero.

A synchronous reset starts a sweep that writes the mid-scale value 0x80 into one slot per cycle. The `busy` output stays high while the sweep runs, and the block ignores writes and reads during that time.

Top module: `circ_window`

## Requirements
- R1: Sample width DATA_W (default 8) and window depth DEPTH (default 66) are parameters. Elaboration rejects DEPTH below 2 and DATA_W below 2.
- R2: After `rst` falls, `busy` stays high for exactly DEPTH clock edges and then goes low.
- R3: While `busy` or `rst` is high, `wr_en` and `rd_en` have no effect. `rd_data` does not change, and the window left after the sweep holds only the fill value.
- R4: Once the sweep ends, every one of the DEPTH window positions reads 0x80 (offset-binary mid-scale, 1 followed by DATA_W-1 zeros).
- R5: An accepted write makes `wr_data` the newest window entry and drops the oldest entry.
- R6: On each read, `rd_data` shows, one edge later, the entry at the current read position counted from the oldest (0) to the newest (DEPTH-1). Without a read, `rd_data` holds its value.
- R7: The read position advances by one on each accepted read and wraps from DEPTH-1 to 0. Writes do not move it, and it returns to 0 on reset.
- R8: When a write and a read are accepted on the same edge, the read returns the window as it stood before that write.
- R9: The write pointer wraps modulo DEPTH for both power-of-two and other depths. After more than DEPTH writes, the window holds exactly the last DEPTH samples in arrival order.
- R10: `rst` sets `rd_data` to 0x80 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts the fill sweep |
| wr_en | input | 1 | Append `wr_data` as the newest sample |
| wr_data | input | DATA_W | Sample to append |
| rd_en | input | 1 | Read the entry at the current read position and advance |
| rd_data | output | DATA_W | Registered window entry |
| busy | output | 1 | Fill sweep in progress; inputs ignored |

## Verification
The bench builds two copies of the block side by side from the same inputs: one with DEPTH=6, which takes the modulo-compare wrap path, and one with DEPTH=4, which takes the power-of-two truncation path. Both use DATA_W=8. These small depths let a few dozen cycles cover several write-pointer wraps, read-position wraps in the middle of a session, and sweeps of different lengths. The bench also checks same-edge write and read and a reset issued during operation against a shifting reference window.

// File: rtl/circ_window_pkg.sv
package circ_window_pkg;

   typedef enum logic {
      CW_CLEAR = 1'b0,
      CW_RUN   = 1'b1
   } cw_phase_e;

   function automatic int unsigned cw_addr_w(input int unsigned depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/cw_mod_add.sv
module cw_mod_add #(
   parameter int unsigned MODULUS = 66,
   parameter int unsigned W       = 7
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   localparam bit IS_POW2 = (MODULUS == (1 << W));

   generate
      if (IS_POW2) begin : g_pow2
         // natural truncation performs the wrap
         assign sum = a + b;
      end else begin : g_cmp
         localparam logic [W:0] MOD_WIDE = (W+1)'(MODULUS);
         logic [W:0] wide;
         assign wide = {1'b0, a} + {1'b0, b};
         assign sum  = (wide >= MOD_WIDE) ? W'(wide - MOD_WIDE) : wide[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/cw_ctrl.sv
module cw_ctrl
   import circ_window_pkg::*;
#(
   parameter int unsigned DEPTH = 66,
   parameter int unsigned AW    = 7
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic          rd_en,
   output logic          busy,
   output logic          wr_fire,
   output logic          rd_fire,
   output logic [AW-1:0] wr_ptr,
   output logic [AW-1:0] rd_pos,
   output logic [AW-1:0] clr_addr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [AW-1:0] ONE  = AW'(1);

   cw_phase_e     phase;
   logic [AW-1:0] wr_ptr_nx;
   logic [AW-1:0] rd_pos_nx;

   cw_mod_add #(.MODULUS(DEPTH), .W(AW)) u_wr_inc (
      .a(wr_ptr), .b(ONE), .sum(wr_ptr_nx)
   );
   cw_mod_add #(.MODULUS(DEPTH), .W(AW)) u_rd_inc (
      .a(rd_pos), .b(ONE), .sum(rd_pos_nx)
   );

   assign busy    = (phase == CW_CLEAR);
   assign wr_fire = !busy && wr_en;
   assign rd_fire = !busy && rd_en;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase    <= CW_CLEAR;
         clr_addr <= '0;
         wr_ptr   <= '0;
         rd_pos   <= '0;
      end else begin
         case (phase)
            CW_CLEAR: begin
               clr_addr <= clr_addr + ONE;
               if (clr_addr == LAST) phase <= CW_RUN;
            end
            default: begin
               if (wr_fire) wr_ptr <= wr_ptr_nx;
               if (rd_fire) rd_pos <= rd_pos_nx;
            end
         endcase
      end
   end

   // R2: reset always leaves the block sweeping
   a_r2_busy_after_reset: assert property (@(posedge clk) rst |=> busy);

   // R9: write pointer never leaves the window
   a_r9_wptr_in_range: assert property (@(posedge clk) disable iff (rst)
      wr_ptr <= LAST);

   // R7: read position wraps at the last window position
   a_r7_rpos_wrap: assert property (@(posedge clk) disable iff (rst)
      (rd_fire && rd_pos == LAST) |=> rd_pos == '0);

   // R3: pointers frozen during the sweep
   a_r3_ptrs_frozen_busy: assert property (@(posedge clk) disable iff (rst)
      busy |=> ($stable(wr_ptr) && $stable(rd_pos)));
endmodule

// File: rtl/cw_store.sv
module cw_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 66,
   parameter int unsigned AW     = 7,
   parameter logic [DATA_W-1:0] FILL = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst)     rdata <= FILL;
      else if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/circ_window.sv
module circ_window
   import circ_window_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned DEPTH  = 66
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy
);
   localparam int unsigned       AW   = cw_addr_w(DEPTH);
   localparam logic [DATA_W-1:0] FILL = DATA_W'(1) << (DATA_W - 1);

   // R1: parameter legality
   initial begin
      a_r1_depth_ok: assert (DEPTH >= 2) else $error("DEPTH must be >= 2");
      a_r1_width_ok: assert (DATA_W >= 2) else $error("DATA_W must be >= 2");
   end

   logic          wr_fire, rd_fire;
   logic [AW-1:0] wr_ptr, rd_pos, clr_addr, rd_addr;
   logic          st_we;
   logic [AW-1:0] st_waddr;
   logic [DATA_W-1:0] st_wdata;

   cw_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_ctrl (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
      .busy(busy), .wr_fire(wr_fire), .rd_fire(rd_fire),
      .wr_ptr(wr_ptr), .rd_pos(rd_pos), .clr_addr(clr_addr)
   );

   // oldest slot sits at wr_ptr, so offset the read position from it
   cw_mod_add #(.MODULUS(DEPTH), .W(AW)) u_rd_addr (
      .a(wr_ptr), .b(rd_pos), .sum(rd_addr)
   );

   assign st_we    = busy | wr_fire;
   assign st_waddr = busy ? clr_addr : wr_ptr;
   assign st_wdata = busy ? FILL : wr_data;

   cw_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW), .FILL(FILL)) u_store (
      .clk(clk), .rst(rst), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
      .re(rd_fire), .raddr(rd_addr), .rdata(rd_data)
   );

   // R6: output only moves on an accepted read
   a_r6_hold_without_read: assert property (@(posedge clk) disable iff (rst)
      !rd_fire |=> $stable(rd_data));

   // R10: reset loads the fill value
   a_r10_reset_output: assert property (@(posedge clk) rst |=> rd_data == FILL);
endmodule

// File: tb/circ_window_bench.sv
module circ_window_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd6, rd4;
   logic       busy6, busy4;

   always #5 clk = ~clk;

   circ_window #(.DATA_W(8), .DEPTH(6)) u_circ_window (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd6), .busy(busy6)
   );
   circ_window #(.DATA_W(8), .DEPTH(4)) u_circ_window_p2 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd4), .busy(busy4)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [7:0] m6 [6];
   logic [7:0] m4 [4];
   int rp6, rp4;
   logic [7:0] last6, last4;

   // {wr, rd, data}
   localparam logic [9:0] VEC [16] = '{
      {1'b1,1'b0,8'h11}, {1'b1,1'b0,8'h22}, {1'b0,1'b1,8'h00}, {1'b1,1'b1,8'h33},
      {1'b0,1'b0,8'h00}, {1'b1,1'b0,8'h44}, {1'b0,1'b1,8'h00}, {1'b0,1'b1,8'h00},
      {1'b1,1'b1,8'h55}, {1'b1,1'b0,8'h66}, {1'b1,1'b0,8'h77}, {1'b0,1'b1,8'h00},
      {1'b1,1'b1,8'h88}, {1'b0,1'b1,8'h00}, {1'b0,1'b0,8'h00}, {1'b0,1'b1,8'h00}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_fill();
      for (int i = 0; i < 6; i++) m6[i] = 8'h80;
      for (int i = 0; i < 4; i++) m4[i] = 8'h80;
      rp6 = 0; rp4 = 0; last6 = 8'h80; last4 = 8'h80;
   endtask

   // one cycle of stimulus, compared against the shifting reference windows
   task automatic step(input bit w, input logic [7:0] d, input bit r, input string tag);
      @(negedge clk);
      wr_en = w; wr_data = d; rd_en = r;
      @(posedge clk); #1;
      if (r) begin
         last6 = m6[rp6]; last4 = m4[rp4];   // pre-write window (R8)
         rp6 = (rp6 + 1) % 6; rp4 = (rp4 + 1) % 4;
      end
      check(rd6 == last6, {tag, " d6"}, rd6, last6);
      check(rd4 == last4, {tag, " d4"}, rd4, last4);
      if (w) begin
         for (int i = 0; i < 5; i++) m6[i] = m6[i+1];
         m6[5] = d;
         for (int i = 0; i < 3; i++) m4[i] = m4[i+1];
         m4[3] = d;
      end
   endtask

   task automatic do_reset();
      int low6, low4;
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h55;
      @(negedge clk); @(negedge clk);
      check(rd6 == 8'h80, "R10 d6", rd6, 8'h80);
      check(rd4 == 8'h80, "R10 d4", rd4, 8'h80);
      check(busy6 && busy4, "R2 busy in reset", {busy6, busy4}, 2'b11);
      rst = 1'b0;
      low6 = 0; low4 = 0;
      for (int k = 1; k <= 12; k++) begin
         @(posedge clk); #1;
         if (!busy6 && low6 == 0) low6 = k;
         if (!busy4 && low4 == 0) low4 = k;
         if (k <= 3) begin
            check(rd6 == 8'h80 && rd4 == 8'h80, "R3 ignored while busy",
                  {rd6, rd4}, 16'h8080);
         end
         if (k == 3) begin
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
         end
      end
      check(low6 == 6, "R2 sweep len d6", low6, 6);
      check(low4 == 4, "R2 sweep len d4", low4, 4);
      model_fill();
   endtask

   initial begin
      model_fill();
      do_reset();

      // R4 / R3: full sweep of window reads fill value
      for (int i = 0; i < 6; i++) step(1'b0, 8'h00, 1'b1, "R4 fill read");
      check(rp6 == 0, "R7 session end", rp6, 0);

      // table of mixed patterns (R5 R6 R8)
      for (int v = 0; v < 16; v++)
         step(VEC[v][9], VEC[v][7:0], VEC[v][8], "R5 table");

      // R9: many writes wrap both write pointers
      for (int i = 0; i < 9; i++) step(1'b1, 8'hA0 + 8'(i), 1'b0, "R9 wrap writes");
      // align read position to zero, then oldest-first session (R6)
      while (rp6 != 0) step(1'b0, 8'h00, 1'b1, "R7 align");
      for (int i = 0; i < 6; i++) begin
         step(1'b0, 8'h00, 1'b1, "R6 session");
         check(rd6 == 8'hA3 + 8'(i), "R9 last six in order", rd6, 8'hA3 + 8'(i));
      end
      // R7: reads crossing the wrap
      for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 1'b1, "R7 wrap read");
      // R8: simultaneous write and read
      for (int i = 0; i < 5; i++) step(1'b1, 8'hC0 + 8'(i), 1'b1, "R8 same edge");
      step(1'b0, 8'h00, 1'b0, "R6 hold");
      step(1'b0, 8'h00, 1'b0, "R6 hold");

      // reset during operation, then window is fill again
      do_reset();
      for (int i = 0; i < 7; i++) step(1'b0, 8'h00, 1'b1, "R4 after rerst");

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule